// File: doc/BRIEF.md
# Quad-Lane Word Deserializer

This block rebuilds a 28-bit parallel word from four serial data lanes plus a fifth lane that carries the word-rate clock. A single bit-rate clock, running at seven times the word rate, samples all five lanes. The block finds the word boundary from the framing lane. It shifts seven bits out of each lane and presents the result as one parallel word, together with a word strobe whose rising edge marks new data.

Around the datapath sits a small link controller. An active-low power-down input clears all outputs. After power-down is released, the controller waits a settle interval before it accepts framing. It declares lock only after the framing lane has shown two boundaries exactly one word apart. When the framing lane goes quiet, the controller freezes the last word, stops the strobe and drops lock.

Top module: `quad_lane_deser`

## Requirements
- R1: Output bit 7k+j equals the bit that data lane k carried in slot j of the word. Slot 0 is the bit sampled in the same bit clock as the framing boundary, and slots 1 to 6 are the next six bit clocks.
- R2: Over one word the framing lane is high in slots 0 to 3 and low in slots 4 to 6. A boundary is a sample of 1 whose preceding sample was 0.
- R3: While locked, `word_out` takes the new word on the bit-clock edge that samples slot 6. `word_stb` rises on that same edge, stays high for four bit clocks and then stays low for three. `word_stb` is never high while `locked` is low.
- R4: Once `pwr_dn_n` has been sampled low, `word_out`, `word_stb` and `locked` are all 0 after that edge, and they stay 0 for as long as `pwr_dn_n` remains low.
- R5: After reset is released, or `pwr_dn_n` returns high, `locked` and `word_stb` stay low for at least SETTLE_CYC bit clocks, even when valid framing is present.
- R6: Lock is set only at a boundary that comes exactly 7 bit clocks after the previous boundary. A lone boundary does not lock. The first word delivered is the one that starts at the locking boundary.
- R7: If 14 consecutive bit clocks pass with no boundary, `locked` falls on the 14th. `word_stb` stays low from the bit clock after the last slot 6, and `word_out` keeps the last word whatever the data lanes carry.
- R8: While locked, a boundary that arrives at any spacing other than 7 bit clocks drops `locked`. No word is delivered until R6 is met again.
- R9: While `rst` is high, `word_out`, `word_stb` and `locked` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate sampling clock, seven per word |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dn_n | input | 1 | Active-low power-down |
| lane_in | input | 4 | Serial data lanes, bit k is lane k |
| frm_in | input | 1 | Framing lane carrying the word-rate clock |
| word_out | output | 28 | Rebuilt parallel word |
| word_stb | output | 1 | Word strobe, rising edge marks new data |
| locked | output | 1 | Framing established |

## Verification
The hardest states to reach from the ports are the ones where framing breaks while the link is locked. One is a boundary that arrives early. The other is a framing lane that stops while the data lanes keep toggling. The stimulus cuts one word short after four slots to force an early boundary, and it holds the framing lane at 0 for twenty bit clocks while random bits keep flowing on the data lanes. Lock is checked at exactly the 13th and 14th quiet clocks. Relock is then driven with a lone boundary followed by a correctly spaced one, so the test can show that only the second word is delivered.

// File: rtl/deser_pkg.sv
package deser_pkg;

    // Link controller states
    typedef enum logic [1:0] {
        LNK_DOWN   = 2'd0,
        LNK_SETTLE = 2'd1,
        LNK_HUNT   = 2'd2,
        LNK_LOCKED = 2'd3
    } link_state_e;

    // Per-bit-clock framing events from the framer
    typedef struct packed {
        logic aligned;     // boundary exactly one word after the previous one
        logic misaligned;  // boundary at any other spacing
        logic loss;        // quiet interval reached the loss limit
        logic last_slot;   // this sample is the final slot of a word
        logic strobe_win;  // slot where the strobe may stay high
    } frame_evt_t;

    // Number of slots the strobe stays high
    function automatic int unsigned strobe_high(input int unsigned slots);
        return (slots + 1) / 2;
    endfunction

endpackage

// File: rtl/deser_framer.sv
module deser_framer
    import deser_pkg::*;
#(
    parameter int SLOTS    = 7,
    parameter int LOSS_CYC = 14
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frm_in,
    output frame_evt_t evt
);
    localparam int SAT        = LOSS_CYC + 1;
    localparam int CW         = $clog2(SAT + 1);
    localparam int HOLD_SLOTS = int'(strobe_high(SLOTS)) - 2;

    localparam logic [CW-1:0] C_SLOTS = CW'(SLOTS);
    localparam logic [CW-1:0] C_LAST  = CW'(SLOTS - 1);
    localparam logic [CW-1:0] C_LOSS  = CW'(LOSS_CYC);
    localparam logic [CW-1:0] C_SAT   = CW'(SAT);
    localparam logic [CW-1:0] C_HOLD  = CW'(HOLD_SLOTS);

    logic          prev_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] slot_now;
    logic          rise;

    assign rise     = frm_in & ~prev_q;
    assign slot_now = rise ? '0 : cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            cnt_q  <= C_SAT;
        end else begin
            prev_q <= frm_in;
            if (rise)
                cnt_q <= CW'(1);
            else if (cnt_q != C_SAT)
                cnt_q <= cnt_q + CW'(1);
        end
    end

    always_comb begin
        evt.aligned    = rise && (cnt_q == C_SLOTS);
        evt.misaligned = rise && (cnt_q != C_SLOTS);
        evt.loss       = !rise && (cnt_q == C_LOSS);
        evt.last_slot  = !rise && (cnt_q == C_LAST);
        evt.strobe_win = slot_now <= C_HOLD;
    end

endmodule

// File: rtl/deser_lane.sv
module deser_lane #(
    parameter int SLOTS = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_in,
    output logic [SLOTS-1:0] slots_o
);
    logic [SLOTS-2:0] sh_q;

    // Oldest bit drifts toward bit 0, so slot j lands at index j
    always_ff @(posedge clk) begin
        if (rst)
            sh_q <= '0;
        else
            sh_q <= {bit_in, sh_q[SLOTS-2:1]};
    end

    assign slots_o = {bit_in, sh_q};

endmodule

// File: rtl/deser_ctrl.sv
module deser_ctrl
    import deser_pkg::*;
#(
    parameter int SETTLE_CYC = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_dn_n,
    input  frame_evt_t evt,
    output logic       load_o,
    output logic       locked_o,
    output logic       stb_o
);
    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam logic [SW-1:0] C_SETTLE_END = SW'(SETTLE_CYC - 1);

    link_state_e   state_q, state_n;
    logic [SW-1:0] scnt_q, scnt_n;
    logic          stb_q, stb_n, lock_n;

    always_comb begin
        state_n = state_q;
        scnt_n  = scnt_q;
        if (!pwr_dn_n) begin
            state_n = LNK_DOWN;
            scnt_n  = '0;
        end else begin
            unique case (state_q)
                LNK_DOWN: begin
                    state_n = LNK_SETTLE;
                    scnt_n  = '0;
                end
                LNK_SETTLE: begin
                    if (scnt_q == C_SETTLE_END)
                        state_n = LNK_HUNT;
                    else
                        scnt_n = scnt_q + SW'(1);
                end
                LNK_HUNT: begin
                    if (evt.aligned)
                        state_n = LNK_LOCKED;
                end
                LNK_LOCKED: begin
                    if (evt.loss || evt.misaligned)
                        state_n = LNK_HUNT;
                end
                default: state_n = LNK_DOWN;
            endcase
        end
    end

    assign lock_n = (state_n == LNK_LOCKED);
    assign load_o = lock_n && evt.last_slot;
    assign stb_n  = lock_n && (load_o || (stb_q && evt.strobe_win));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LNK_DOWN;
            scnt_q  <= '0;
            stb_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            scnt_q  <= scnt_n;
            stb_q   <= stb_n;
        end
    end

    assign locked_o = (state_q == LNK_LOCKED);
    assign stb_o    = stb_q;

    AST_LOSS_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
        evt.loss |=> !locked_o); // R7

    AST_ALIGN_LOCKS: assert property (@(posedge clk) disable iff (rst)
        (state_q == LNK_HUNT && evt.aligned && pwr_dn_n) |=> locked_o); // R6

    AST_SKEW_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
        (locked_o && evt.misaligned) |=> !locked_o); // R8

endmodule

// File: rtl/quad_lane_deser.sv
module quad_lane_deser
    import deser_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int SLOTS      = 7,
    parameter int SETTLE_CYC = 64,
    parameter int LOSS_CYC   = 14
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   pwr_dn_n,
    input  logic [LANES-1:0]       lane_in,
    input  logic                   frm_in,
    output logic [LANES*SLOTS-1:0] word_out,
    output logic                   word_stb,
    output logic                   locked
);
    localparam int WORD_W = LANES * SLOTS;

    frame_evt_t                  evt;
    logic                        load;
    logic [LANES-1:0][SLOTS-1:0] lane_slots;
    logic [WORD_W-1:0]           word_q;

    deser_framer #(.SLOTS(SLOTS), .LOSS_CYC(LOSS_CYC)) u_framer (
        .clk    (clk),
        .rst    (rst),
        .frm_in (frm_in),
        .evt    (evt)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        deser_lane #(.SLOTS(SLOTS)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .bit_in  (lane_in[g]),
            .slots_o (lane_slots[g])
        );
    end

    deser_ctrl #(.SETTLE_CYC(SETTLE_CYC)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .pwr_dn_n (pwr_dn_n),
        .evt      (evt),
        .load_o   (load),
        .locked_o (locked),
        .stb_o    (word_stb)
    );

    always_ff @(posedge clk) begin
        if (rst || !pwr_dn_n)
            word_q <= '0;
        else if (load)
            word_q <= lane_slots;
    end

    assign word_out = word_q;

    AST_PD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !pwr_dn_n |=> (word_out == '0 && !word_stb && !locked)); // R4

    AST_STB_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        word_stb |-> locked); // R3

    AST_WORD_ON_STB: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && word_out != $past(word_out))
            |-> ($rose(word_stb) || !$past(pwr_dn_n))); // R3

endmodule

// File: tb/quad_lane_deser_test.sv
module quad_lane_deser_test;
    localparam int SETTLE = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwr_dn_n = 1'b1;
    logic [3:0]  lanes = '0;
    logic        frm = 1'b0;
    logic [27:0] word_out;
    logic        word_stb;
    logic        locked;

    int n_checks = 0;
    int n_fail   = 0;
    int edges    = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) edges++;

    quad_lane_deser #(.SETTLE_CYC(SETTLE)) uut (
        .clk(clk), .rst(rst), .pwr_dn_n(pwr_dn_n), .lane_in(lanes),
        .frm_in(frm), .word_out(word_out), .word_stb(word_stb), .locked(locked)
    );

    task automatic check(input bit ok, input string req,
                         input logic [27:0] act, input logic [27:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive_slot(input logic f, input logic [3:0] l);
        frm   = f;
        lanes = l;
        @(negedge clk);
    endtask

    // Framing lane high in slots 0..3 (R2); lane k slot j carries bit 7k+j (R1)
    task automatic send_word(input logic [27:0] w, input bit chk_stb);
        for (int s = 0; s < 7; s++) begin
            logic [3:0] l;
            bit         e;
            for (int k = 0; k < 4; k++) l[k] = w[k*7+s];
            drive_slot(s < 4, l);
            e = (s == 6) || (s <= 2);
            if (chk_stb)
                check(word_stb == e, "R3 strobe shape", {27'b0, word_stb}, {27'b0, e});
        end
    endtask

    task automatic deliver(input logic [27:0] w);
        send_word(w, 1'b1);
        check(word_out == w, "R1 R2 word", word_out, w);
    endtask

    task automatic settle_phase();
        int t0;
        t0 = edges;
        for (int i = 0; i < 12; i++) begin
            logic [27:0] w;
            int          e;
            w = 28'($urandom);
            send_word(w, 1'b0);
            e = edges - t0;
            if (e <= SETTLE)
                check(!locked && !word_stb, "R5 settle hold-off",
                      {26'b0, locked, word_stb}, 28'd0);
            else if (e >= SETTLE + 23)
                check(word_out == w, "R6 first words", word_out, w);
        end
        check(locked, "R6 locked after settle", {27'b0, locked}, 28'd1);
    endtask

    initial begin
        logic [27:0] last, a, b, c, d;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        check(word_out == '0 && !word_stb && !locked, "R9 reset state",
              {word_out[25:0], word_stb, locked}, 28'd0);
        rst = 1'b0;
        settle_phase();

        // Directed data patterns
        deliver(28'hFFFFFFF);
        deliver(28'h0000000);
        for (int k = 0; k < 4; k++) deliver(28'h7F << (7 * k));
        deliver(28'h0000001);
        deliver(28'h0000040);
        deliver(28'h0000080);
        deliver(28'h8000000);
        for (int i = 0; i < 24; i++) deliver(28'($urandom));
        last = 28'h5A5A5A5;
        deliver(last);

        // R7: framing lane stops, data lanes keep moving
        for (int i = 1; i <= 20; i++) begin
            drive_slot(1'b0, 4'($urandom));
            check(!word_stb, "R7 strobe stopped", {27'b0, word_stb}, 28'd0);
            check(word_out == last, "R7 word held", word_out, last);
            if (i == 7) check(locked, "R7 lock before limit", {27'b0, locked}, 28'd1);
            if (i == 8) check(!locked, "R7 lock lost", {27'b0, locked}, 28'd0);
        end

        // R6: a lone boundary does not lock, the next one does
        a = 28'($urandom);
        send_word(a, 1'b0);
        check(!locked, "R6 lone boundary", {27'b0, locked}, 28'd0);
        check(word_out == last, "R6 no word yet", word_out, last);
        b = 28'($urandom);
        send_word(b, 1'b0);
        check(locked && word_out == b, "R6 relock word", word_out, b);
        last = 28'($urandom);
        deliver(last);

        // R8: short word gives an early boundary
        for (int s = 0; s < 4; s++) drive_slot(s < 3, 4'($urandom));
        c = 28'($urandom);
        send_word(c, 1'b0);
        check(!locked, "R8 early boundary unlock", {27'b0, locked}, 28'd0);
        check(word_out == last && !word_stb, "R8 nothing delivered", word_out, last);
        d = 28'($urandom);
        send_word(d, 1'b0);
        check(locked && word_out == d, "R8 relock", word_out, d);

        // R4: power-down
        deliver(28'h1234567);
        pwr_dn_n = 1'b0;
        drive_slot(1'b1, 4'hF);
        check(word_out == '0 && !word_stb && !locked, "R4 power-down clears",
              {word_out[25:0], word_stb, locked}, 28'd0);
        for (int i = 0; i < 3; i++) begin
            send_word(28'($urandom), 1'b0);
            check(word_out == '0 && !word_stb && !locked, "R4 stays low",
                  {word_out[25:0], word_stb, locked}, 28'd0);
        end
        pwr_dn_n = 1'b1;
        settle_phase();
        for (int i = 0; i < 6; i++) deliver(28'($urandom));

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule